// File: doc/BRIEF.md
# Floating-Point Status Register Group

This block stores the two pieces of floating-point control state that software sees: a 5-bit field of sticky exception flags and a 3-bit rounding-mode field. Software reaches them through three register views on one access port. The first view shows only the flags. The second shows only the rounding mode. The third is a combined word that holds both fields. The floating-point datapath raises exception flags on a separate input, and those flags are ORed into the stored field. The stored rounding mode is driven out continuously to that datapath.

Access to all three views depends on the floating-point enable state, which another block holds and supplies here as a 2-bit input. When that state is off, every access is refused and changes nothing. When a write succeeds, the block raises a one-cycle request that tells the owner of the enable state to mark it dirty.

A small access FSM handles each request. The states are IDLE, READ_ACK, WRITE_ACK and DENY. A request presented in any state moves the FSM to READ_ACK, WRITE_ACK or DENY at the next clock edge. A cycle with no request returns the FSM to IDLE. All response outputs are decoded from the current state.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset, the flags field and the rounding-mode field are zero, `rmode_out` is 0, and `rsp_valid`, `rsp_err` and `fs_dirty_set` are low.
- R2: A request sampled at clock edge k produces `rsp_valid` high for exactly the cycle after edge k. `rsp_valid` is low after any edge at which no request was sampled.
- R3: View code 0 is the flags view. It reads as the flags in bits [4:0] with zeros above. A write through it updates only the flags, taken from bits [4:0] of the merged value.
- R4: View code 1 is the rounding-mode view. It reads as the rounding mode in bits [2:0] with zeros above. A write through it updates only the rounding mode, taken from bits [2:0] of the merged value.
- R5: View code 2 is the combined word. It holds the flags in bits [4:0] and the rounding mode in bits [7:5], and bits above 7 read as zero. A write through it updates both fields from those bit positions.
- R6: The value written is (old & ~wmask) | (wdata & wmask). An all-zero `csr_wmask` makes the access a plain read that changes nothing.
- R7: When `fs_state` is 2'b00, the access is refused. `rsp_err` is high, `rsp_rdata` is 0, neither field changes, and `fs_dirty_set` stays low.
- R8: `fs_dirty_set` is high together with the response of every access that is accepted and has a nonzero `csr_wmask`. It is never high at any other time.
- R9: In a cycle where `fpu_flag_valid` is high, `fpu_flags` is ORed into the stored flags at the next edge, and the flags stay set until software writes them.
- R10: If an accepted write that updates the flags (view 0 or 2) arrives in the same cycle as a valid flag input, the written value wins. A write through view 1 does not block the flag accumulation.
- R11: View code 3 is reserved. Any access to it is refused, with the same behaviour as R7.
- R12: `rmode_out` always equals the stored rounding mode. It changes at the edge where a write to view 1 or view 2 is accepted.
- R13: `rsp_rdata` returns the value of the addressed view as it stood before any write made by the same access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | Access request this cycle |
| csr_view | input | 2 | View select: 0 flags, 1 rounding mode, 2 combined, 3 reserved |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Per-bit write enable; zero means read only |
| fs_state | input | 2 | Floating-point enable state; 2'b00 means off |
| fpu_flag_valid | input | 1 | Exception flags from the datapath are valid |
| fpu_flags | input | 5 | Exception flags to accumulate |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | The access was refused |
| rsp_rdata | output | XLEN | Previous value of the addressed view |
| fs_dirty_set | output | 1 | Request to set the enable state to dirty (2'b11) |
| rmode_out | output | 3 | Current rounding mode |

## Verification
A corrupted field shows up on the next read of any view that includes it, one cycle after that read is requested. For the rounding mode it also shows up immediately on `rmode_out`. An FSM that lands in the wrong state shows in the very next cycle as a wrong combination of `rsp_valid`, `rsp_err` and `fs_dirty_set`. A lost or spurious flag accumulation stays hidden until the next flags or combined read. For that reason the bench reads back after every accumulation and after every write.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

    typedef enum logic [1:0] {
        VIEW_FLAGS = 2'd0,
        VIEW_RMODE = 2'd1,
        VIEW_WORD  = 2'd2,
        VIEW_RSVD  = 2'd3
    } fp_view_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_ACK  = 2'd1,
        ST_WRITE_ACK = 2'd2,
        ST_DENY      = 2'd3
    } acc_state_e;

    localparam logic [1:0] FS_OFF   = 2'b00;
    localparam logic [1:0] FS_DIRTY = 2'b11;

endpackage

// File: rtl/fpcsr_view_mux.sv
module fpcsr_view_mux
    import fpcsr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3
) (
    input  fp_view_e          view,
    input  logic [FLAG_W-1:0] flags,
    input  logic [RM_W-1:0]   rmode,
    input  logic [XLEN-1:0]   wdata,
    input  logic [XLEN-1:0]   wmask,
    output logic [XLEN-1:0]   old_val,
    output logic [FLAG_W-1:0] new_flags,
    output logic [RM_W-1:0]   new_rmode,
    output logic              hits_flags,
    output logic              hits_rmode,
    output logic              view_ok
);
    localparam int WORD_W = FLAG_W + RM_W;

    logic [XLEN-1:0] merged;

    always_comb begin
        unique case (view)
            VIEW_FLAGS: old_val = XLEN'(flags);
            VIEW_RMODE: old_val = XLEN'(rmode);
            VIEW_WORD:  old_val = XLEN'({rmode, flags});
            default:    old_val = '0;
        endcase
    end

    assign merged = (old_val & ~wmask) | (wdata & wmask);

    always_comb begin
        new_flags  = flags;
        new_rmode  = rmode;
        hits_flags = 1'b0;
        hits_rmode = 1'b0;
        view_ok    = 1'b1;
        unique case (view)
            VIEW_FLAGS: begin
                new_flags  = merged[FLAG_W-1:0];
                hits_flags = 1'b1;
            end
            VIEW_RMODE: begin
                new_rmode  = merged[RM_W-1:0];
                hits_rmode = 1'b1;
            end
            VIEW_WORD: begin
                new_flags  = merged[FLAG_W-1:0];
                new_rmode  = merged[WORD_W-1:FLAG_W];
                hits_flags = 1'b1;
                hits_rmode = 1'b1;
            end
            default: view_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpcsr_fields.sv
module fpcsr_fields #(
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              rm_we,
    input  logic [RM_W-1:0]   rm_wdata,
    input  logic              acc_valid,
    input  logic [FLAG_W-1:0] acc_flags,
    output logic [FLAG_W-1:0] flags,
    output logic [RM_W-1:0]   rmode
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (flag_we) begin
            flags <= flag_wdata;
        end else if (acc_valid) begin
            flags <= flags | acc_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmode <= '0;
        end else if (rm_we) begin
            rmode <= rm_wdata;
        end
    end

    // R9: accumulation is an OR into the previous flags
    a_r9_sticky_or: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !flag_we) |=> (flags == ($past(flags) | $past(acc_flags))));

    // R10: a CSR write to the flags beats accumulation
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> (flags == $past(flag_wdata)));

    a_r12_rmode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rm_we |=> $stable(rmode));
endmodule

// File: rtl/fpcsr_ctrl.sv
module fpcsr_ctrl
    import fpcsr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_req,
    input  logic            view_ok,
    input  logic            wmask_any,
    input  logic [1:0]      fs_state,
    input  logic [XLEN-1:0] old_val,
    output logic            commit,
    output logic            rsp_valid,
    output logic            rsp_err,
    output logic            fs_dirty_set,
    output logic [XLEN-1:0] rsp_rdata
);
    acc_state_e state_q, state_d;
    logic       allowed;
    logic       req_rsvd;

    assign allowed  = view_ok && (fs_state != FS_OFF);
    assign commit   = csr_req && allowed && wmask_any;
    assign req_rsvd = csr_req && !view_ok;

    always_comb begin
        state_d = ST_IDLE;
        if (csr_req) begin
            if (!allowed)       state_d = ST_DENY;
            else if (wmask_any) state_d = ST_WRITE_ACK;
            else                state_d = ST_READ_ACK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  rsp_rdata <= '0;
        else if (csr_req && allowed) rsp_rdata <= old_val;
        else                         rsp_rdata <= '0;
    end

    always_comb begin
        rsp_valid    = 1'b0;
        rsp_err      = 1'b0;
        fs_dirty_set = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_ACK: rsp_valid = 1'b1;
            ST_WRITE_ACK: begin
                rsp_valid    = 1'b1;
                fs_dirty_set = 1'b1;
            end
            ST_DENY: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end

    a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        csr_req |=> rsp_valid);

    a_r2_no_ack_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_req |=> !rsp_valid);

    a_r7_deny_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!fs_dirty_set && rsp_rdata == '0));

    a_r11_rsvd_refused: assert property (@(posedge clk) disable iff (!rst_n)
        req_rsvd |=> rsp_err);
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
    import fpcsr_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int FLAG_W = 5,
    parameter int RM_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req,
    input  logic [1:0]        csr_view,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [XLEN-1:0]   csr_wmask,
    input  logic [1:0]        fs_state,
    input  logic              fpu_flag_valid,
    input  logic [FLAG_W-1:0] fpu_flags,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              fs_dirty_set,
    output logic [RM_W-1:0]   rmode_out
);
    logic [FLAG_W-1:0] flags, new_flags;
    logic [RM_W-1:0]   rmode, new_rmode;
    logic [XLEN-1:0]   old_val;
    logic              hits_flags, hits_rmode, view_ok, commit;

    fpcsr_view_mux #(.XLEN(XLEN), .FLAG_W(FLAG_W), .RM_W(RM_W)) u_mux (
        .view       (fp_view_e'(csr_view)),
        .flags      (flags),
        .rmode      (rmode),
        .wdata      (csr_wdata),
        .wmask      (csr_wmask),
        .old_val    (old_val),
        .new_flags  (new_flags),
        .new_rmode  (new_rmode),
        .hits_flags (hits_flags),
        .hits_rmode (hits_rmode),
        .view_ok    (view_ok)
    );

    fpcsr_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_req      (csr_req),
        .view_ok      (view_ok),
        .wmask_any    (|csr_wmask),
        .fs_state     (fs_state),
        .old_val      (old_val),
        .commit       (commit),
        .rsp_valid    (rsp_valid),
        .rsp_err      (rsp_err),
        .fs_dirty_set (fs_dirty_set),
        .rsp_rdata    (rsp_rdata)
    );

    fpcsr_fields #(.FLAG_W(FLAG_W), .RM_W(RM_W)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_we    (commit && hits_flags),
        .flag_wdata (new_flags),
        .rm_we      (commit && hits_rmode),
        .rm_wdata   (new_rmode),
        .acc_valid  (fpu_flag_valid),
        .acc_flags  (fpu_flags),
        .flags      (flags),
        .rmode      (rmode)
    );

    assign rmode_out = rmode;

    a_r8_dirty_only_ok: assert property (@(posedge clk) disable iff (!rst_n)
        fs_dirty_set |-> (rsp_valid && !rsp_err));

    a_r7_fs_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && fs_state == FS_OFF) |=> $stable(rmode_out));
endmodule

// File: tb/sim_fpcsr_unit.sv
module sim_fpcsr_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_req = 1'b0;
    logic [1:0]      csr_view = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_wmask = '0;
    logic [1:0]      fs_state = 2'b11;
    logic            fpu_flag_valid = 1'b0;
    logic [4:0]      fpu_flags = '0;
    logic            rsp_valid, rsp_err, fs_dirty_set;
    logic [XLEN-1:0] rsp_rdata;
    logic [2:0]      rmode_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [4:0] m_flags = '0;
    logic [2:0] m_rm = '0;

    always #2.5 clk = ~clk;

    fpcsr_unit u0 (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_view(csr_view),
        .csr_wdata(csr_wdata), .csr_wmask(csr_wmask), .fs_state(fs_state),
        .fpu_flag_valid(fpu_flag_valid), .fpu_flags(fpu_flags),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .fs_dirty_set(fs_dirty_set), .rmode_out(rmode_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] view_val(input logic [1:0] v);
        case (v)
            2'd0: return {27'd0, m_flags};
            2'd1: return {29'd0, m_rm};
            2'd2: return {24'd0, m_rm, m_flags};
            default: return 32'd0;
        endcase
    endfunction

    // one access; optional simultaneous flag input
    task automatic access(input string tag, input logic [1:0] v, input logic [31:0] wd,
                          input logic [31:0] wm, input logic [1:0] fs,
                          input logic accv, input logic [4:0] accf);
        logic        ok;
        logic [31:0] old, mrg;
        @(negedge clk);
        csr_req = 1'b1; csr_view = v; csr_wdata = wd; csr_wmask = wm; fs_state = fs;
        fpu_flag_valid = accv; fpu_flags = accf;
        ok  = (fs != 2'b00) && (v != 2'd3);
        old = view_val(v);
        mrg = (old & ~wm) | (wd & wm);
        if (accv) m_flags = m_flags | accf;
        if (ok && wm != 0) begin
            if (v == 2'd0) m_flags = mrg[4:0];
            if (v == 2'd1) m_rm = mrg[2:0];
            if (v == 2'd2) begin m_flags = mrg[4:0]; m_rm = mrg[7:5]; end
        end
        @(negedge clk);
        csr_req = 1'b0; fpu_flag_valid = 1'b0; csr_wmask = '0;
        chk({tag, " R2 valid"}, {31'd0, rsp_valid}, 32'd1);
        chk({tag, " R7/R11 err"}, {31'd0, rsp_err}, {31'd0, !ok});
        chk({tag, " R13 rdata"}, rsp_rdata, ok ? old : 32'd0);
        chk({tag, " R8 dirty"}, {31'd0, fs_dirty_set}, {31'd0, ok && wm != 0});
        chk({tag, " R12 rmode_out"}, {29'd0, rmode_out}, {29'd0, m_rm});
    endtask

    task automatic rd(input string tag, input logic [1:0] v);
        access(tag, v, 32'd0, 32'd0, 2'b11, 1'b0, 5'd0);
    endtask

    task automatic accumulate(input logic [4:0] f);
        @(negedge clk);
        fpu_flag_valid = 1'b1; fpu_flags = f;
        m_flags = m_flags | f;
        @(negedge clk);
        fpu_flag_valid = 1'b0;
        chk("R2 idle no valid", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 rsp_err", {31'd0, rsp_err}, 32'd0);
        chk("R1 dirty", {31'd0, fs_dirty_set}, 32'd0);
        chk("R1 rmode_out", {29'd0, rmode_out}, 32'd0);
        rst_n = 1'b1;
        rd("R1 word after reset", 2'd2);

        // R3 flags view sweep, junk in upper bits
        for (int i = 0; i < 32; i++) begin
            access("R3 wr", 2'd0, 32'hFFFF_FFE0 | i, 32'hFFFF_FFFF, 2'b11, 1'b0, 5'd0);
            rd("R3 rd word", 2'd2);
        end
        // R4 rounding-mode sweep
        for (int i = 0; i < 8; i++) begin
            access("R4 wr", 2'd1, 32'hFFFF_FFF8 | i, 32'hFFFF_FFFF, 2'b11, 1'b0, 5'd0);
            rd("R4 rd flags", 2'd0);
            rd("R4 rd word", 2'd2);
        end
        // R5 combined sweep
        for (int i = 0; i < 256; i++) begin
            access("R5 wr", 2'd2, 32'hA5A5_A500 | i, 32'hFFFF_FFFF, 2'b11, 1'b0, 5'd0);
            rd("R5 rd flags", 2'd0);
            rd("R5 rd rmode", 2'd1);
        end
        // R6 mask set/clear patterns
        access("R6 clear all", 2'd2, 32'd0, 32'hFF, 2'b11, 1'b0, 5'd0);
        for (int m = 0; m < 256; m += 17) begin
            access("R6 set", 2'd2, 32'hFFFF_FFFF, m, 2'b11, 1'b0, 5'd0);
            access("R6 clear", 2'd2, 32'd0, {24'd0, 8'(m ^ 8'h3C)}, 2'b11, 1'b0, 5'd0);
            access("R6 zero mask", 2'd2, 32'hFFFF_FFFF, 32'd0, 2'b11, 1'b0, 5'd0);
            rd("R6 rd", 2'd2);
        end
        // R7 / R11 enable-state and view sweep
        access("setup", 2'd2, 32'h96, 32'hFF, 2'b11, 1'b0, 5'd0);
        for (int fs = 0; fs < 4; fs++) begin
            for (int v = 0; v < 4; v++) begin
                access("R7 R11 sweep wr", 2'(v), 32'h0000_0069 ^ (fs * 32'h21), 32'hFF, 2'(fs), 1'b0, 5'd0);
                access("R7 R11 sweep rd", 2'(v), 32'd0, 32'd0, 2'(fs), 1'b0, 5'd0);
                rd("R7 R11 readback", 2'd2);
            end
        end
        // R9 accumulation, sticky
        access("R9 clear", 2'd0, 32'd0, 32'h1F, 2'b11, 1'b0, 5'd0);
        accumulate(5'b00001); rd("R9 rd1", 2'd0);
        accumulate(5'b10000); rd("R9 rd2", 2'd0);
        accumulate(5'b00000); rd("R9 rd3", 2'd2);
        accumulate(5'b01110); rd("R9 rd4", 2'd0);
        // R10 collision cases
        access("R10 flags write wins", 2'd0, 32'h2, 32'h1F, 2'b11, 1'b1, 5'b11101);
        rd("R10 rd a", 2'd0);
        access("R10 word write wins", 2'd2, 32'hE0, 32'hFF, 2'b11, 1'b1, 5'b10101);
        rd("R10 rd b", 2'd2);
        access("R10 rmode write keeps acc", 2'd1, 32'h3, 32'h7, 2'b11, 1'b1, 5'b01010);
        rd("R10 rd c", 2'd2);
        access("R10 refused write keeps acc", 2'd0, 32'h0, 32'h1F, 2'b00, 1'b1, 5'b00001);
        rd("R10 rd d", 2'd2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule